// File: doc/BRIEF.md
# Operand Cache Read and Prefetch Controller

This block controls a small set-associative operand cache that serves CPU loads and prefetch hints one at a time. It looks up the tag arrays in the cycle a request is accepted. On a hit it returns the stored word, or for a prefetch only refreshes the replacement order. On a miss it picks a victim way. If that victim is dirty, it first hands the whole line to a write-back buffer. It then fetches the new line from external memory one word per beat. The fetch starts at the requested word and wraps around the line, so the CPU gets its word as soon as the first beat lands.

Dirty bits are set by the neighbouring store logic through a narrow mark port. The controller only clears them, when a line is refilled, and reads them, to decide whether a victim needs a write-back. While a miss is being serviced the controller raises a stall and takes no new request.

Top module: `opcache_rdctl`

## Requirements
- R1: Reset behaviour.
  - After reset, every line is invalid and every set's recency order is way 0 newest through way 3 oldest.
  - `cpuBusy`, `cpuRespValid`, `memReqValid` and `wbValid` are low.
- R2: Read hit.
  - A read that hits asserts `cpuRespValid` for exactly one cycle, in the cycle after acceptance.
  - `cpuRespData` carries the stored word, and no memory request is issued.
- R3: Miss handling.
  - A miss issues exactly one single-cycle memory request.
  - `memReqAddr` is the missed word's address with bits [1:0] zero.
  - `cpuBusy` is high from the cycle after acceptance until the cycle after the last beat.
- R4: Wrap-around refill.
  - A line refill takes four beats. Beat k is stored at word offset (missed offset + k) mod 4, where the word offset is address bits [3:2].
  - The set index is bits [9:4] and the tag is bits [31:10].
  - All four words of the refilled line later hit with the memory contents.
- R5: Critical word first. On a read miss, `cpuRespValid` pulses once, carrying the first beat's data, in the cycle after the first beat is taken, while `cpuBusy` is still high.
- R6: Victim choice.
  - The victim is the lowest-numbered invalid way of the set if one exists, otherwise the least recently used way.
  - A completed refill leaves the line valid.
- R7: Recency update. A read hit, a prefetch hit and a completed refill each make the way concerned the most recently used. The other ways keep their relative order.
- R8: Dirty victim write-back.
  - `wbValid` presents the victim's line address, its four words (word i at bits [32i+31:32i]) and the missed word offset in `wbFirstWord`.
  - These stay stable until `wbReady`.
  - The memory request is raised only after that handshake.
- R9: Dirty bits on refill. A refill clears the line's dirty bit, so a later eviction of that line produces no write-back. A clean victim produces no write-back.
- R10: Prefetch hit. A prefetch hit returns no response, issues no memory request and only changes the recency order.
- R11: Prefetch miss. A prefetch miss refills the line exactly as a read miss does but never asserts `cpuRespValid`.
- R12: Dirty mark port. A cycle with `markValid` high sets the dirty bit of way `markWay` in set `markSet`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReqValid | input | 1 | Request present; accepted when `cpuBusy` is low |
| cpuReqPrefetch | input | 1 | 1 = prefetch, 0 = read |
| cpuReqAddr | input | 32 | Byte address of the request |
| cpuBusy | output | 1 | Miss in service; requests are not accepted |
| cpuRespValid | output | 1 | Read data valid pulse |
| cpuRespData | output | 32 | Read data |
| memReqValid | output | 1 | Single-cycle line fetch request |
| memReqAddr | output | 32 | Address of the first word to fetch |
| memRespValid | input | 1 | Refill beat valid |
| memRespData | input | 32 | Refill beat data |
| wbValid | output | 1 | Dirty victim line offered |
| wbReady | input | 1 | Write-back buffer accepts the line |
| wbAddr | output | 32 | Victim line base address |
| wbData | output | 128 | Victim line words |
| wbFirstWord | output | 2 | Word offset at which to start writing back |
| markValid | input | 1 | Set a dirty bit |
| markSet | input | 6 | Set index for the mark |
| markWay | input | 2 | Way for the mark |

## Verification
A corrupt tag, valid bit or recency rank is not visible at once. It shows up at the ports on the next access to that set, as an unexpected memory request, a missing one, or a write-back of the wrong line. A misplaced refill word shows up as wrong data on the next hit to that offset. A response-path fault shows in the very cycle after the first beat, or after the accepting edge. The scenarios therefore fill a set completely and then evict from it under a known order, so that every victim decision becomes a visible memory or write-back transaction within a few cycles.

// File: rtl/opcache_rdctl_pkg.sv
package opcache_rdctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_MREQ  = 2'd2,
    ST_FILL  = 2'd3
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // request latched, lookup result used this cycle
    logic beat;     // refill word arriving
    logic finish;   // last refill word, line becomes valid
  } dpStrobe_t;

endpackage

// File: rtl/opcache_rdctl_ctrl.sv
module opcache_rdctl_ctrl
  import opcache_rdctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       lookupHit,
  input  logic       victimDirty,
  input  logic       beatLast,
  input  logic       wbReady,
  input  logic       memRespValid,
  output dpStrobe_t  strobe,
  output logic       busy,
  output logic       wbValid,
  output logic       memReqValid
);

  ctlState_e state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.accept = 1'b1;
          if (!lookupHit) nextState = victimDirty ? ST_WBACK : ST_MREQ;
        end
      end
      ST_WBACK: if (wbReady) nextState = ST_MREQ;
      ST_MREQ:  nextState = ST_FILL;
      ST_FILL: begin
        if (memRespValid) begin
          strobe.beat = 1'b1;
          if (beatLast) begin
            strobe.finish = 1'b1;
            nextState     = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy        = (state != ST_IDLE);
  assign wbValid     = (state == ST_WBACK);
  assign memReqValid = (state == ST_MREQ);

  // R3: the fetch request is a one-cycle pulse
  assert_mem_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R8: a fetch following a write-back offer only comes after the handshake
  assert_mem_after_handshake_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(memReqValid) && $past(wbValid)) |-> $past(wbReady));

endmodule

// File: rtl/opcache_rdctl_dp.sv
module opcache_rdctl_dp
  import opcache_rdctl_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int NUM_WAYS   = 4,
  parameter int NUM_SETS   = 64,
  parameter int LINE_WORDS = 4,
  parameter int ADDR_W     = 32,
  localparam int WAY_W  = $clog2(NUM_WAYS),
  localparam int IDX_W  = $clog2(NUM_SETS),
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int BYTE_W = $clog2(WORD_W / 8),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobe_t                    strobe,
  input  logic [ADDR_W-BYTE_W-1:0]     reqWordAddr,
  input  logic                         reqPrefetch,
  input  logic                         memRespData_v,
  input  logic [WORD_W-1:0]            memRespData,
  input  logic                         wbValid,
  input  logic                         wbReady,
  input  logic                         markValid,
  input  logic [IDX_W-1:0]             markSet,
  input  logic [WAY_W-1:0]             markWay,
  output logic                         lookupHit,
  output logic                         victimDirty,
  output logic                         beatLast,
  output logic                         respValid,
  output logic [WORD_W-1:0]            respData,
  output logic [ADDR_W-1:0]            memReqAddr,
  output logic [ADDR_W-1:0]            wbAddr,
  output logic [LINE_WORDS*WORD_W-1:0] wbData,
  output logic [OFF_W-1:0]             wbFirstWord
);

  // storage
  logic [WORD_W-1:0]   dataArr  [NUM_SETS][NUM_WAYS][LINE_WORDS];
  logic [TAG_W-1:0]    tagArr   [NUM_SETS][NUM_WAYS];
  logic [WAY_W-1:0]    ageArr   [NUM_SETS][NUM_WAYS];   // 0 = newest
  logic [NUM_WAYS-1:0] validArr [NUM_SETS];
  logic [NUM_WAYS-1:0] dirtyArr [NUM_SETS];

  // incoming request fields
  logic [TAG_W-1:0] inTag;
  logic [IDX_W-1:0] inIdx;
  logic [OFF_W-1:0] inWord;
  assign inWord = reqWordAddr[OFF_W-1:0];
  assign inIdx  = reqWordAddr[OFF_W +: IDX_W];
  assign inTag  = reqWordAddr[ADDR_W-BYTE_W-1 -: TAG_W];

  // request in service
  logic [TAG_W-1:0] curTag;
  logic [IDX_W-1:0] curIdx;
  logic [OFF_W-1:0] curWord;
  logic [WAY_W-1:0] curVictim;
  logic             curPf;
  logic [OFF_W-1:0] beatCnt;

  // lookup
  logic [NUM_WAYS-1:0] hitVec;
  logic [WAY_W-1:0]    hitWay;
  always_comb begin
    hitVec = '0;
    hitWay = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      hitVec[w] = validArr[inIdx][w] && (tagArr[inIdx][w] == inTag);
      if (hitVec[w]) hitWay = WAY_W'(w);
    end
  end
  assign lookupHit = |hitVec;

  // victim: lowest invalid way, else oldest way
  logic [WAY_W-1:0] victimWay;
  logic             gotFree;
  always_comb begin
    victimWay = '0;
    gotFree   = 1'b0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (!validArr[inIdx][w] && !gotFree) begin
        victimWay = WAY_W'(w);
        gotFree   = 1'b1;
      end
    end
    if (!gotFree) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (ageArr[inIdx][w] == WAY_W'(NUM_WAYS - 1)) victimWay = WAY_W'(w);
      end
    end
  end
  assign victimDirty = validArr[inIdx][victimWay] && dirtyArr[inIdx][victimWay];

  // recency update
  logic             touchEn;
  logic [IDX_W-1:0] touchIdx;
  logic [WAY_W-1:0] touchWay;
  assign touchEn  = (strobe.accept && lookupHit) || strobe.finish;
  assign touchIdx = strobe.finish ? curIdx : inIdx;
  assign touchWay = strobe.finish ? curVictim : hitWay;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          ageArr[s][w] <= WAY_W'(w);
    end else if (touchEn) begin
      for (int v = 0; v < NUM_WAYS; v++) begin
        if (WAY_W'(v) == touchWay)
          ageArr[touchIdx][v] <= '0;
        else if (ageArr[touchIdx][v] < ageArr[touchIdx][touchWay])
          ageArr[touchIdx][v] <= ageArr[touchIdx][v] + WAY_W'(1);
      end
    end
  end

  // line status bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        validArr[s] <= '0;
        dirtyArr[s] <= '0;
      end
    end else begin
      if (markValid) dirtyArr[markSet][markWay] <= 1'b1;
      if (strobe.finish) begin
        validArr[curIdx][curVictim] <= 1'b1;
        dirtyArr[curIdx][curVictim] <= 1'b0;
      end
    end
  end

  // data and tag arrays (no reset)
  logic [OFF_W-1:0] fillWord;
  assign fillWord = curWord + beatCnt;

  always_ff @(posedge clk) begin
    if (strobe.beat)   dataArr[curIdx][curVictim][fillWord] <= memRespData;
    if (strobe.finish) tagArr[curIdx][curVictim] <= curTag;
  end

  // request registers and response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTag    <= '0;
      curIdx    <= '0;
      curWord   <= '0;
      curVictim <= '0;
      curPf     <= 1'b0;
      beatCnt   <= '0;
      respValid <= 1'b0;
      respData  <= '0;
    end else begin
      respValid <= 1'b0;
      if (strobe.accept) begin
        curTag    <= inTag;
        curIdx    <= inIdx;
        curWord   <= inWord;
        curVictim <= victimWay;
        curPf     <= reqPrefetch;
        beatCnt   <= '0;
        if (lookupHit && !reqPrefetch) begin
          respValid <= 1'b1;
          respData  <= dataArr[inIdx][hitWay][inWord];
        end
      end
      if (strobe.beat) begin
        beatCnt <= beatCnt + OFF_W'(1);
        if (beatCnt == '0 && !curPf) begin
          respValid <= 1'b1;
          respData  <= memRespData;
        end
      end
    end
  end

  assign beatLast    = (beatCnt == OFF_W'(LINE_WORDS - 1));
  assign memReqAddr  = {curTag, curIdx, curWord, {BYTE_W{1'b0}}};
  assign wbAddr      = {tagArr[curIdx][curVictim], curIdx, {(OFF_W + BYTE_W){1'b0}}};
  assign wbFirstWord = curWord;

  genvar gi;
  generate
    for (gi = 0; gi < LINE_WORDS; gi++) begin : g_wbPack
      assign wbData[gi*WORD_W +: WORD_W] = dataArr[curIdx][curVictim][gi];
    end
  endgenerate

  // recency ranks of the set in service stay a permutation
  logic [NUM_WAYS-1:0] ageSeen;
  always_comb begin
    ageSeen = '0;
    for (int w = 0; w < NUM_WAYS; w++) ageSeen[ageArr[curIdx][w]] = 1'b1;
  end

  assert_age_permutation_R7: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ageSeen) == NUM_WAYS);

  // R10, R11: a prefetch never produces a response
  assert_pf_silent_R10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !curPf);

  // R6, R9: a finished refill leaves the line valid and clean
  assert_fill_clean_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.finish) |-> (validArr[curIdx][curVictim] && !dirtyArr[curIdx][curVictim]));

  // R8: the offered line holds until accepted
  assert_wb_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbReady) |=> (wbValid && $stable(wbAddr) && $stable(wbData)));

  // refill beats are only taken while a refill is in progress
  assert_beat_has_data_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.beat |-> memRespData_v);

endmodule

// File: rtl/opcache_rdctl.sv
module opcache_rdctl
  import opcache_rdctl_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int NUM_WAYS   = 4,
  parameter int NUM_SETS   = 64,
  parameter int LINE_WORDS = 4,
  parameter int ADDR_W     = 32
)(
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 cpuReqValid,
  input  logic                                 cpuReqPrefetch,
  input  logic [ADDR_W-1:0]                    cpuReqAddr,
  output logic                                 cpuBusy,
  output logic                                 cpuRespValid,
  output logic [WORD_W-1:0]                    cpuRespData,
  output logic                                 memReqValid,
  output logic [ADDR_W-1:0]                    memReqAddr,
  input  logic                                 memRespValid,
  input  logic [WORD_W-1:0]                    memRespData,
  output logic                                 wbValid,
  input  logic                                 wbReady,
  output logic [ADDR_W-1:0]                    wbAddr,
  output logic [LINE_WORDS*WORD_W-1:0]         wbData,
  output logic [$clog2(LINE_WORDS)-1:0]        wbFirstWord,
  input  logic                                 markValid,
  input  logic [$clog2(NUM_SETS)-1:0]          markSet,
  input  logic [$clog2(NUM_WAYS)-1:0]          markWay
);

  localparam int BYTE_W = $clog2(WORD_W / 8);

  dpStrobe_t strobe;
  logic      lookupHit, victimDirty, beatLast;

  logic unusedByteBits;
  assign unusedByteBits = ^cpuReqAddr[BYTE_W-1:0];

  opcache_rdctl_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (cpuReqValid),
    .lookupHit    (lookupHit),
    .victimDirty  (victimDirty),
    .beatLast     (beatLast),
    .wbReady      (wbReady),
    .memRespValid (memRespValid),
    .strobe       (strobe),
    .busy         (cpuBusy),
    .wbValid      (wbValid),
    .memReqValid  (memReqValid)
  );

  opcache_rdctl_dp #(
    .WORD_W     (WORD_W),
    .NUM_WAYS   (NUM_WAYS),
    .NUM_SETS   (NUM_SETS),
    .LINE_WORDS (LINE_WORDS),
    .ADDR_W     (ADDR_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .reqWordAddr   (cpuReqAddr[ADDR_W-1:BYTE_W]),
    .reqPrefetch   (cpuReqPrefetch),
    .memRespData_v (memRespValid),
    .memRespData   (memRespData),
    .wbValid       (wbValid),
    .wbReady       (wbReady),
    .markValid     (markValid),
    .markSet       (markSet),
    .markWay       (markWay),
    .lookupHit     (lookupHit),
    .victimDirty   (victimDirty),
    .beatLast      (beatLast),
    .respValid     (cpuRespValid),
    .respData      (cpuRespData),
    .memReqAddr    (memReqAddr),
    .wbAddr        (wbAddr),
    .wbData        (wbData),
    .wbFirstWord   (wbFirstWord)
  );

endmodule

// File: tb/opcache_rdctl_bench.sv
module opcache_rdctl_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic         rstN = 1'b0;
  logic         cpuReqValid = 1'b0, cpuReqPrefetch = 1'b0;
  logic [31:0]  cpuReqAddr = '0;
  logic         cpuBusy, cpuRespValid;
  logic [31:0]  cpuRespData;
  logic         memReqValid;
  logic [31:0]  memReqAddr;
  logic         memRespValid = 1'b0;
  logic [31:0]  memRespData = '0;
  logic         wbValid;
  logic         wbReady = 1'b0;
  logic [31:0]  wbAddr;
  logic [127:0] wbData;
  logic [1:0]   wbFirstWord;
  logic         markValid = 1'b0;
  logic [5:0]   markSet = '0;
  logic [1:0]   markWay = '0;

  opcache_rdctl u_opcache_rdctl (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cpuReqValid), .cpuReqPrefetch(cpuReqPrefetch), .cpuReqAddr(cpuReqAddr),
    .cpuBusy(cpuBusy), .cpuRespValid(cpuRespValid), .cpuRespData(cpuRespData),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRespValid(memRespValid), .memRespData(memRespData),
    .wbValid(wbValid), .wbReady(wbReady), .wbAddr(wbAddr), .wbData(wbData),
    .wbFirstWord(wbFirstWord),
    .markValid(markValid), .markSet(markSet), .markWay(markWay)
  );

  int checks = 0;
  int fails  = 0;

  function automatic logic [31:0] patt(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0F1E2D3C;
  endfunction

  function automatic logic [31:0] mkAddr(input int t, input int s, input int w);
    return (32'(t) << 10) | (32'(s) << 4) | (32'(w) << 2);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one request, with memory and write-back buffer modelled cycle by cycle
  task automatic access(input logic [31:0] addr, input bit pf, input bit expMiss,
                        input bit expWb, input logic [31:0] expWbBase, input string tag);
    int reqAt = -1, respCnt = 0, respAt = -1, memCnt = 0, wbCnt = 0;
    bit busyAtResp = 0, memDuringWb = 0, busyAfter = 0;
    logic [31:0]  respD = '0, memA = '0, wbA = '0;
    logic [127:0] wbD = '0;
    logic [1:0]   wbF = '0;
    @(negedge clk);
    cpuReqValid = 1'b1; cpuReqPrefetch = pf; cpuReqAddr = addr;
    @(negedge clk);
    cpuReqValid = 1'b0;
    busyAfter = cpuBusy;
    for (int cyc = 0; cyc < 60; cyc++) begin
      int k;
      int b;
      logic [1:0] off;
      if (cyc > 0) @(negedge clk);
      memRespValid = 1'b0;
      if (cpuRespValid) begin
        respCnt++; respAt = cyc; respD = cpuRespData; busyAtResp = cpuBusy;
      end
      if (wbValid) begin
        if (wbCnt == 0) begin wbA = wbAddr; wbD = wbData; wbF = wbFirstWord; end
        wbCnt++;
        if (memReqValid) memDuringWb = 1;
      end
      wbReady = wbValid && (wbCnt >= 3);
      if (memReqValid) begin memCnt++; reqAt = cyc; memA = memReqAddr; end
      if (reqAt >= 0) begin
        k = cyc - reqAt;
        b = (k == 1) ? 0 : (k == 2) ? 1 : (k == 4) ? 2 : (k == 5) ? 3 : -1;
        if (b >= 0) begin
          off = memA[3:2] + 2'(b);
          memRespValid = 1'b1;
          memRespData  = patt({memA[31:4], off, 2'b00});
        end
      end
      if (!cpuBusy && !memRespValid) break;
    end
    memRespValid = 1'b0;
    wbReady = 1'b0;
    check(tag, "miss (memory request count)", 32'(memCnt), 32'(expMiss));
    check("R3", "busy after acceptance", 32'(busyAfter), 32'(expMiss));
    check("R3", "busy released", 32'(cpuBusy), 32'd0);
    if (expMiss && memCnt == 1)
      check("R3", "fetch address", memA, {addr[31:2], 2'b00});
    if (pf) begin
      check(expMiss ? "R11" : "R10", "prefetch responses", 32'(respCnt), 32'd0);
    end else if (!expMiss) begin
      check("R2", "hit response count", 32'(respCnt), 32'd1);
      check("R2", "hit response cycle", 32'(respAt), 32'd0);
      check("R2", "hit data", respD, patt(addr));
    end else begin
      check("R5", "miss response count", 32'(respCnt), 32'd1);
      check("R5", "miss response cycle", 32'(respAt), 32'(reqAt + 2));
      check("R5", "miss response while busy", 32'(busyAtResp), 32'd1);
      check("R5", "critical word data", respD, patt(addr));
    end
    check(expWb ? "R8" : "R9", "write-back offered", 32'(wbCnt > 0), 32'(expWb));
    if (expWb) begin
      check("R8", "write-back address", wbA, expWbBase);
      check("R8", "write-back first word", 32'(wbF), 32'(addr[3:2]));
      check("R8", "fetch during write-back", 32'(memDuringWb), 32'd0);
      for (int i = 0; i < 4; i++)
        check("R8", "write-back word", wbD[i*32 +: 32], patt(expWbBase + 32'(i * 4)));
    end
  endtask

  task automatic markDirty(input int s, input int w);
    @(negedge clk);
    markValid = 1'b1; markSet = 6'(s); markWay = 2'(w);
    @(negedge clk);
    markValid = 1'b0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  localparam int SET_A = 9;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    check("R1", "busy", 32'(cpuBusy), 32'd0);
    check("R1", "resp valid", 32'(cpuRespValid), 32'd0);
    check("R1", "mem request", 32'(memReqValid), 32'd0);
    check("R1", "wb valid", 32'(wbValid), 32'd0);

    // R4 sweep: miss at every start offset, then hit every word (R1: cold lines miss)
    for (int s = 0; s < 4; s++) begin
      access(mkAddr(7, s, s), 1'b0, 1'b1, 1'b0, 32'h0, "R1");
      for (int w = 0; w < 4; w++)
        access(mkAddr(7, s, w), 1'b0, 1'b0, 1'b0, 32'h0, "R4");
    end

    // fill one set: ways 0..3 in order (R6), one by prefetch (R11)
    access(mkAddr(1, SET_A, 1), 1'b0, 1'b1, 1'b0, 32'h0, "R6");
    access(mkAddr(2, SET_A, 2), 1'b1, 1'b1, 1'b0, 32'h0, "R11");
    access(mkAddr(3, SET_A, 3), 1'b0, 1'b1, 1'b0, 32'h0, "R6");
    access(mkAddr(4, SET_A, 0), 1'b0, 1'b1, 1'b0, 32'h0, "R6");
    // prefetched line readable at every word (R11)
    for (int w = 0; w < 4; w++)
      access(mkAddr(2, SET_A, w), 1'b0, 1'b0, 1'b0, 32'h0, "R11");
    // order now newest->oldest: t2,t4,t3,t1. read hit t1, prefetch hit t2 (R7, R10)
    access(mkAddr(1, SET_A, 0), 1'b0, 1'b0, 1'b0, 32'h0, "R7");
    access(mkAddr(2, SET_A, 3), 1'b1, 1'b0, 1'b0, 32'h0, "R10");
    // newest->oldest: t2,t1,t4,t3 ; oldest is t3 in way 2, mark it dirty (R12)
    markDirty(SET_A, 2);
    access(mkAddr(5, SET_A, 2), 1'b0, 1'b1, 1'b1, mkAddr(3, SET_A, 0), "R12");
    // survivors still hit (R7)
    access(mkAddr(1, SET_A, 1), 1'b0, 1'b0, 1'b0, 32'h0, "R7");
    access(mkAddr(2, SET_A, 1), 1'b0, 1'b0, 1'b0, 32'h0, "R7");
    access(mkAddr(4, SET_A, 1), 1'b0, 1'b0, 1'b0, 32'h0, "R7");
    // evicted line misses now; victim oldest t5 in way 2, dirty bit was cleared (R9)
    access(mkAddr(3, SET_A, 0), 1'b0, 1'b1, 1'b0, 32'h0, "R9");
    // t3 newest again; t5 evicted from way 2 reloads cleanly, t1 then oldest (R6)
    access(mkAddr(5, SET_A, 0), 1'b0, 1'b1, 1'b0, 32'h0, "R6");
    access(mkAddr(1, SET_A, 2), 1'b0, 1'b1, 1'b0, 32'h0, "R6");
    access(mkAddr(3, SET_A, 3), 1'b0, 1'b0, 1'b0, 32'h0, "R2");

    summary();
    $finish;
  end

endmodule